// File: doc/BRIEF.md
# Programmable-Latency Burst Read Engine

This block is the device side of a clocked burst read. The host programs a small configuration register with a first-word delay, a hold mode and a burst word count. The host then selects the device by driving both active-low chip enable and output enable low. The engine waits the programmed delay and presents 16-bit words from a page buffer, one word per clock or one word per two clocks. It stops after exactly the programmed number of words. The page buffer is a simple synchronous memory. A separate write port fills it.

Reads are destructive. Every word that is put on the bus counts as consumed, and the next burst starts at the word after the last one presented. If the host drops either enable before the burst is over, the engine aborts at once. When a burst completes, the last word stays on the bus. Any further clocks change nothing until the host deselects the device.

In this brief, E0 is the first rising edge at which both enables are sampled low. Edge index k counts rising edges from E0, so E0 is k = 0. An output "after edge k" is the value it holds between edge k and edge k+1. L is the delay, H is the hold bit and N is the word count, all captured at E0.

Top module: `burst_read_engine`

## Requirements
- R1: While reset is asserted, and afterwards until a burst starts, `data_oe`, `data_valid` and `burst_done` are 0.
- R2: The delay field `cfg_lat` is 3 bits (0 to 7). The first word is presented after edge L+1, so the host can latch it at edge L+2. `data_oe` stays 0 before that.
- R3: With hold = 0, word w is presented after edge L+1+w. Words come from consecutive buffer addresses.
- R4: With hold = 1, word w is presented after edges L+1+2w and L+2+2w. It holds the same value for both cycles.
- R5: `data_valid` is 1 after edges L+1 through L+N·(H+1), and 0 at every other time. Exactly N words are presented, for N from 1 to 63.
- R6: After a complete burst, `data_oe` stays 1 and `data_out` keeps the last word for as long as both enables stay low. Extra clock edges change no output.
- R7: `burst_done` is 1 only after edge L+1+N·(H+1), for exactly one cycle. An aborted burst gives no pulse.
- R8: If `ce_n` or `oe_n` is sampled high during a burst, the outputs after that edge are `data_oe` = 0, `data_valid` = 0 and `burst_done` = 0. A new burst needs both enables low again.
- R9: A word count of 0 starts no burst. No output rises, and no buffer word is consumed.
- R10: Each word presented consumes one buffer address. The next burst, including one after an abort, starts at the address after the last word presented. Addresses wrap modulo the buffer depth.
- R11: The delay, hold and count are captured at E0. A configuration write during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_lat | input | 3 | Extra first-word delay, 0 to 7 cycles |
| cfg_hold | input | 1 | 1 = each word is held for two cycles |
| cfg_len | input | 6 | Burst word count; 0 is illegal and starts nothing |
| buf_we | input | 1 | Page buffer write strobe |
| buf_waddr | input | 8 | Page buffer write address |
| buf_wdata | input | 16 | Page buffer write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| data_out | output | 16 | Read data; 0 when the bus is not driven |
| data_oe | output | 1 | 1 = the data bus is driven |
| data_valid | output | 1 | 1 while a burst word is being presented |
| burst_done | output | 1 | One-cycle pulse after the final word of a complete burst |

## Verification
The bench covers the delay extremes 0 and 7 in both hold modes. An off-by-one wait counter would move the whole data window by a cycle. A hold mode that advances on the wrong phase would repeat or skip a word. It also runs a maximum-length burst, a zero-length request and bursts that cross the buffer wrap. A wrong count, or a pointer that rewinds per burst, would send the wrong words or a wrong number of them. Aborts are made with each enable in turn, during the wait and during the transfer. A pointer that charged unread words, or a sequencer that kept driving or pulsed done, would then be visible on the next burst. A configuration write in the middle of a burst checks that a design which reads live fields would cut the burst short.

// File: rtl/bre_pkg.sv
package bre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_PARK = 2'd3
  } bre_state_e;

endpackage

// File: rtl/bre_rst_sync.sv
module bre_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bre_cfg_reg.sv
module bre_cfg_reg #(
  parameter int unsigned LAT_W = 3,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_lat,
  input  logic             wr_hold,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LAT_W-1:0] lat_q,
  output logic             hold_q,
  output logic [LEN_W-1:0] len_q
);

  logic [LAT_W-1:0] lat_d;
  logic             hold_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    lat_d  = lat_q;
    hold_d = hold_q;
    len_d  = len_q;
    if (wr_en) begin
      lat_d  = wr_lat;
      hold_d = wr_hold;
      len_d  = wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      hold_q <= 1'b0;
      len_q  <= '0;
    end else begin
      lat_q  <= lat_d;
      hold_q <= hold_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/bre_page_buf.sv
module bre_page_buf #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/bre_seq.sv
module bre_seq
  import bre_pkg::*;
#(
  parameter int unsigned LAT_W = 3,
  parameter int unsigned LEN_W = 6,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_hold,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             bus_oe,
  output logic             word_valid,
  output logic             done_pulse
);

  bre_state_e       state_q, state_d;
  logic [LAT_W-1:0] wait_q, wait_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             hold_q, hold_d;
  logic             phase_q, phase_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic             done_q, done_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    left_d  = left_q;
    hold_d  = hold_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    rd_en   = 1'b0;
    if (!sel) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_len != '0) begin
            state_d = ST_WAIT;
            wait_d  = cfg_lat;
            hold_d  = cfg_hold;
            left_d  = cfg_len - 1'b1;
          end
        end
        ST_WAIT: begin
          if (wait_q == '0) begin
            rd_en   = 1'b1;
            phase_d = 1'b0;
            state_d = ST_XFER;
          end else begin
            wait_d = wait_q - 1'b1;
          end
        end
        ST_XFER: begin
          if (hold_q && !phase_q) begin
            phase_d = 1'b1;
          end else if (left_q == '0) begin
            state_d = ST_PARK;
            done_d  = 1'b1;
          end else begin
            rd_en   = 1'b1;
            left_d  = left_q - 1'b1;
            phase_d = 1'b0;
          end
        end
        ST_PARK: begin
          state_d = ST_PARK;
        end
        default: state_d = ST_IDLE;
      endcase
    end
    ptr_d = rd_en ? ptr_q + 1'b1 : ptr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      left_q  <= '0;
      hold_q  <= 1'b0;
      phase_q <= 1'b0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      left_q  <= left_d;
      hold_q  <= hold_d;
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
    end
  end

  assign rd_addr    = ptr_q;
  assign word_valid = (state_q == ST_XFER);
  assign bus_oe     = (state_q == ST_XFER) || (state_q == ST_PARK);
  assign done_pulse = done_q;

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned LAT_W = 3,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_hold,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [DW-1:0]    buf_wdata,
  input  logic             ce_n,
  input  logic             oe_n,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             data_valid,
  output logic             burst_done
);

  logic             rst_n_int;
  logic [LAT_W-1:0] lat_r;
  logic             hold_r;
  logic [LEN_W-1:0] len_r;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic             bus_oe;
  logic             sel;

  assign sel = !ce_n && !oe_n;

  bre_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bre_cfg_reg #(.LAT_W(LAT_W), .LEN_W(LEN_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (cfg_we),
    .wr_lat  (cfg_lat),
    .wr_hold (cfg_hold),
    .wr_len  (cfg_len),
    .lat_q   (lat_r),
    .hold_q  (hold_r),
    .len_q   (len_r)
  );

  bre_page_buf #(.DW(DW), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (buf_we),
    .wr_addr (buf_waddr),
    .wr_data (buf_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  bre_seq #(.LAT_W(LAT_W), .LEN_W(LEN_W), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sel        (sel),
    .cfg_lat    (lat_r),
    .cfg_hold   (hold_r),
    .cfg_len    (len_r),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .bus_oe     (bus_oe),
    .word_valid (data_valid),
    .done_pulse (burst_done)
  );

  // bus is quiet (all zero) whenever it is not driven
  for (genvar b = 0; b < DW; b++) begin : g_mask
    assign data_out[b] = rd_data[b] & bus_oe;
  end

  assign data_oe = bus_oe;

endmodule

// File: rtl/burst_read_engine_chk.sv
module burst_read_engine_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic          data_valid,
  input logic          burst_done
);

  // R5
  valid_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> data_oe);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R7
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_done) |-> (data_oe && $past(data_valid)));

  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> (!data_oe && !data_valid && !burst_done));

  // R6
  park_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !data_valid) |=> (!data_oe || $stable(data_out)));

endmodule

bind burst_read_engine burst_read_engine_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .data_valid (data_valid),
  .burst_done (burst_done)
);

// File: tb/burst_read_engine_bench.sv
module burst_read_engine_bench;

  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_lat;
  logic        cfg_hold;
  logic [5:0]  cfg_len;
  logic        buf_we;
  logic [7:0]  buf_waddr;
  logic [15:0] buf_wdata;
  logic        ce_n;
  logic        oe_n;
  logic [15:0] data_out;
  logic        data_oe;
  logic        data_valid;
  logic        burst_done;

  int n_checks = 0;
  int n_errors = 0;
  string cur_tag = "R1";

  burst_read_engine u_burst_read_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
    .cfg_hold(cfg_hold), .cfg_len(cfg_len), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .ce_n(ce_n), .oe_n(oe_n),
    .data_out(data_out), .data_oe(data_oe), .data_valid(data_valid),
    .burst_done(burst_done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_mem [DEPTH];
  int m_lat, m_hold, m_len;
  bit m_active;
  int m_k, m_L, m_H, m_N, m_base;

  function automatic int words_taken();
    int w;
    if (!m_active || m_k < m_L + 1) return 0;
    w = (m_k - m_L - 1) / (m_H + 1) + 1;
    return (w > m_N) ? m_N : w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_base = 0; m_lat = 0; m_hold = 0; m_len = 0; m_k = 0;
    end else begin
      int taken;
      taken = words_taken();
      if (m_active) begin
        if (ce_n || oe_n) begin
          m_base = (m_base + taken) % DEPTH;
          m_active = 0;
        end else begin
          m_k++;
        end
      end else if (!ce_n && !oe_n && m_len != 0) begin
        m_active = 1; m_k = 0; m_L = m_lat; m_H = m_hold; m_N = m_len;
      end
      if (cfg_we) begin
        m_lat = int'(cfg_lat); m_hold = int'(cfg_hold); m_len = int'(cfg_len);
      end
      if (buf_we) m_mem[buf_waddr] = buf_wdata;
    end
  end

  task automatic check1(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_oe, e_valid, e_done;
    int idx;
    e_oe    = m_active && (m_k >= m_L + 1);
    e_valid = e_oe && (m_k <= m_L + m_N * (m_H + 1));
    e_done  = m_active && (m_k == m_L + 1 + m_N * (m_H + 1));
    check1("data_oe", int'(data_oe), int'(e_oe));
    check1("data_valid", int'(data_valid), int'(e_valid));
    check1("burst_done", int'(burst_done), int'(e_done));
    if (e_oe) begin
      idx = (m_k - m_L - 1) / (m_H + 1);
      if (idx > m_N - 1) idx = m_N - 1;
      check1("data_out", int'(data_out), int'(m_mem[(m_base + idx) % DEPTH]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic prog(int l, int h, int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lat = 3'(l); cfg_hold = h[0]; cfg_len = 6'(n);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // hold both enables low for 'cyc' cycles, then release the chosen pin
  task automatic sel_for(int cyc, bit drop_oe);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (cyc) @(negedge clk);
    if (drop_oe) oe_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic full_burst(int l, int h, int n, int park, string tag);
    cur_tag = tag;
    prog(l, h, n);
    sel_for(l + 2 + n * (h + 1) + park, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_lat = '0; cfg_hold = 1'b0; cfg_len = '0;
    buf_we = 1'b0; buf_waddr = '0; buf_wdata = '0; ce_n = 1'b1; oe_n = 1'b1;
    cur_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      buf_we = 1'b1; buf_waddr = 8'(i); buf_wdata = 16'(i * 16'h0125 + 16'h3C00);
      @(negedge clk);
    end
    buf_we = 1'b0;
    // R1: selected with count 0 after reset stays idle
    sel_for(6, 1'b0);
    full_burst(0, 0, 4, 0, "R3");
    full_burst(7, 0, 3, 1, "R2");
    full_burst(0, 1, 5, 0, "R4");
    full_burst(7, 1, 2, 0, "R4");
    full_burst(3, 0, 63, 0, "R5");
    full_burst(2, 1, 3, 9, "R6");
    full_burst(1, 0, 1, 3, "R7");
    full_burst(0, 1, 1, 3, "R7");
    // R8: aborts in transfer, in wait, via either pin; then resumption
    cur_tag = "R8";
    prog(1, 0, 20);
    sel_for(6, 1'b1);
    prog(5, 1, 8);
    sel_for(3, 1'b0);
    prog(0, 1, 8);
    sel_for(4, 1'b0);
    full_burst(0, 0, 4, 0, "R8");
    // R9: zero length consumes nothing
    cur_tag = "R9";
    prog(2, 0, 0);
    sel_for(15, 1'b0);
    full_burst(0, 0, 2, 0, "R9");
    // R11: configuration write in mid-burst
    cur_tag = "R11";
    prog(2, 0, 10);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    cfg_we = 1'b1; cfg_lat = 3'd0; cfg_hold = 1'b1; cfg_len = 6'd2;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (12) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: consecutive bursts wrap the buffer
    for (int r = 0; r < 5; r++) full_burst(0, 0, 63, 0, "R10");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL %s watchdog expired", cur_tag);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule